// File: doc/BRIEF.md
# High-Speed Serial Port Register and Interrupt Controller

This block is the register front end of an 8N1 serial port that runs at 14x oversampling. A 32-bit bus with byte addresses and word-sized registers reaches five registers: the data port, the FIFO fill levels, the interrupt status, the control word and the rate divisor. The shift registers and FIFO storage sit outside the block. They connect through strobes, such as pop and push, and through level and event ports.

Event pulses from the serial paths set sticky status flags. Software clears each flag by writing a one to its bit. The receive-threshold and receive-idle conditions are not sticky: their status bits follow the level inputs directly. The status bits fall into three groups, and each group has its own enable bit in the control word. The block ORs the enabled groups into a single registered interrupt line. A divider produces the oversampling tick. Its period is the rate value plus one clock.

Top module: `sio_hs_regs`

## Requirements
- R1: After reset, the control word and the interrupt status read as zero, the rate reads as 0xFF and `irq` is low.
- R2: Registers sit at byte offsets 0x00 data, 0x04 level, 0x08 status, 0x0C control and 0x10 rate. A read strobe returns its data on `bus_rdata` one cycle later. A read of any other offset returns zero and neither pops nor pushes.
- R3: A data read returns the byte in bits [7:0], receive-empty in bit 8, framing error in bit 9 and break in bit 10. It raises `rx_pop` only when the receive FIFO is not empty.
- R4: A data write raises `tx_push` in the strobe cycle, with `tx_byte` equal to write bits [7:0].
- R5: The level register returns the receive level in bits [7:0] and the transmit level in bits [15:8].
- R6: Status bits 0 (transmit request), 3 (framing), 4 (break) and 5 (overrun) latch their event pulses. Each stays set until a status write carries a one in its bit. A zero in that bit leaves the flag unchanged. An event in the same cycle as a clear leaves the flag set.
- R7: Status bit 1 follows `rx_thresh` and bit 2 follows `rx_idle`. Writing ones to these bits has no effect.
- R8: Control bit 5 enables bit 0, bit 6 enables bits 1 and 2, and bit 7 enables bits 3 to 5. `irq` is the OR of the enabled bits, one cycle after the status changes. Status bit 6 reads as bit 0 AND control bit 5.
- R9: Control bits [17:0] read back as written and bits [31:18] read as zero. `brk_force` reflects control bit 8 and `samp_offset` reflects bits [15:9].
- R10: The rate register keeps write bits [7:0]. `baud_tick` pulses once every rate+1 clocks, and a rate write restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_byte | input | 8 | Head of receive FIFO |
| rx_ferr | input | 1 | Head byte had a framing error |
| rx_brk | input | 1 | Head entry is a break |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_pop | output | 1 | Pop receive FIFO |
| tx_push | output | 1 | Push transmit FIFO |
| tx_byte | output | 8 | Byte to push |
| rx_level | input | 8 | Receive fill level |
| tx_level | input | 8 | Transmit fill level |
| ev_tx_req | input | 1 | Transmit request pulse |
| ev_ferr | input | 1 | Framing error pulse |
| ev_brk | input | 1 | Break pulse |
| ev_ovr | input | 1 | Overrun pulse |
| rx_thresh | input | 1 | Receive threshold reached (level) |
| rx_idle | input | 1 | Receive idle timeout (level) |
| irq | output | 1 | Registered interrupt request |
| baud_tick | output | 1 | Oversampling tick |
| brk_force | output | 1 | Force break on the line |
| samp_offset | output | 7 | Sampling offset |
| rx_thr_sel | output | 3 | Receive threshold select |
| tx_thr_sel | output | 2 | Transmit threshold select |
| idle_sel | output | 2 | Idle timeout select |

## Verification
A flag that is lost or stuck shows on the next status read. Through `irq`, it shows one cycle after the enables allow it. A wrong grouping of enables asserts or drops `irq` on the cycle after the first unmasked event. A decode fault shows up as a stray pop or push in the strobe cycle, or as nonzero data one cycle after a read. Divider faults change the spacing of `baud_tick` from its very next period.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned IDX_DATA  = 0;
  localparam int unsigned IDX_LEVEL = 1;
  localparam int unsigned IDX_STAT  = 2;
  localparam int unsigned IDX_CTRL  = 3;
  localparam int unsigned IDX_RATE  = 4;

  localparam int unsigned NSRC   = 6;
  localparam int unsigned STAT_W = NSRC + 1;
  // which status sources are sticky (write-one-to-clear)
  localparam logic [NSRC-1:0] STICKY = 6'b111001;

  localparam int unsigned CTRL_W = 18;
  typedef struct packed {
    logic [1:0] idle_sel;   // [17:16]
    logic [6:0] offset;     // [15:9]
    logic       brk;        // [8]
    logic       err_en;     // [7]
    logic       rx_en;      // [6]
    logic       tx_en;      // [5]
    logic [2:0] rx_thr;     // [4:2]
    logic [1:0] tx_thr;     // [1:0]
  } ctrl_t;
endpackage

// File: rtl/sio_baud_gen.sv
module sio_baud_gen #(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              restart_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;
  logic              tick_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == rate_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/sio_irq_unit.sv
module sio_irq_unit
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic [NSRC-1:0]   clr_i,
  input  logic              en_tx_i,
  input  logic              en_rx_i,
  input  logic              en_err_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic [NSRC-1:0] flag;
  logic            irq_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (STICKY[i]) begin : g_sticky
      logic f_q;
      always_ff @(posedge clk) begin
        if (rst) f_q <= 1'b0;
        else     f_q <= src_i[i] | (f_q & ~clr_i[i]);
      end
      assign flag[i] = f_q;
    end else begin : g_level
      assign flag[i] = src_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (flag[0] & en_tx_i)
                    | ((flag[1] | flag[2]) & en_rx_i)
                    | ((flag[3] | flag[4] | flag[5]) & en_err_i);
  end

  assign status_o = {flag[0] & en_tx_i, flag};
  assign irq_o    = irq_q;
endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
  import sio_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RATE_W = 8,
  parameter int unsigned LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [7:0]        rx_byte_i,
  input  logic              rx_ferr_i,
  input  logic              rx_brk_i,
  input  logic              rx_empty_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              rx_pop_o,
  output logic              tx_push_o,
  output logic [7:0]        tx_byte_o,
  output logic [NSRC-1:0]   clr_o,
  output ctrl_t             ctrl_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              rate_wr_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              rd_en, wr_en;
  ctrl_t             ctrl_q;
  logic [RATE_W-1:0] rate_q;
  logic [DATA_W-1:0] rmux, rdata_q;

  assign idx   = addr_i[ADDR_W-1:2];
  assign rd_en = sel_i & ~wr_i;
  assign wr_en = sel_i &  wr_i;

  assign rx_pop_o  = rd_en & (idx == IDX_W'(IDX_DATA)) & ~rx_empty_i;
  assign tx_push_o = wr_en & (idx == IDX_W'(IDX_DATA));
  assign tx_byte_o = wdata_i[7:0];
  assign clr_o     = (wr_en && idx == IDX_W'(IDX_STAT)) ?
                     (wdata_i[NSRC-1:0] & STICKY) : '0;
  assign rate_wr_o = wr_en & (idx == IDX_W'(IDX_RATE));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rate_q <= '1;
    end else begin
      if (wr_en && idx == IDX_W'(IDX_CTRL)) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (rate_wr_o)                        rate_q <= wdata_i[RATE_W-1:0];
    end
  end

  always_comb begin
    rmux = '0;
    case (idx)
      IDX_W'(IDX_DATA):  rmux[10:0] = {rx_brk_i, rx_ferr_i, rx_empty_i, rx_byte_i};
      IDX_W'(IDX_LEVEL): rmux[2*LVL_W-1:0] = {tx_level_i, rx_level_i};
      IDX_W'(IDX_STAT):  rmux[STAT_W-1:0] = status_i;
      IDX_W'(IDX_CTRL):  rmux[CTRL_W-1:0] = ctrl_q;
      IDX_W'(IDX_RATE):  rmux[RATE_W-1:0] = rate_q;
      default:           rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rmux;
    else            rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
  assign ctrl_o  = ctrl_q;
  assign rate_o  = rate_q;
endmodule

// File: rtl/sio_hs_regs.sv
module sio_hs_regs
  import sio_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RATE_W = 8,
  parameter int unsigned LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [7:0]        rx_byte,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  input  logic              rx_empty,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic              ev_tx_req,
  input  logic              ev_ferr,
  input  logic              ev_brk,
  input  logic              ev_ovr,
  input  logic              rx_thresh,
  input  logic              rx_idle,
  output logic              irq,
  output logic              baud_tick,
  output logic              brk_force,
  output logic [6:0]        samp_offset,
  output logic [2:0]        rx_thr_sel,
  output logic [1:0]        tx_thr_sel,
  output logic [1:0]        idle_sel
);
  logic [STAT_W-1:0] status_w;
  logic [NSRC-1:0]   clr_w, src_w;
  ctrl_t             ctrl_w;
  logic [RATE_W-1:0] rate_w;
  logic              rate_wr_w;

  assign src_w = {ev_ovr, ev_brk, ev_ferr, rx_idle, rx_thresh, ev_tx_req};

  sio_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATE_W(RATE_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst(rst), .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .rx_byte_i(rx_byte), .rx_ferr_i(rx_ferr),
    .rx_brk_i(rx_brk), .rx_empty_i(rx_empty), .rx_level_i(rx_level), .tx_level_i(tx_level),
    .status_i(status_w), .rx_pop_o(rx_pop), .tx_push_o(tx_push), .tx_byte_o(tx_byte),
    .clr_o(clr_w), .ctrl_o(ctrl_w), .rate_o(rate_w), .rate_wr_o(rate_wr_w)
  );

  sio_irq_unit u_irq (
    .clk(clk), .rst(rst), .src_i(src_w), .clr_i(clr_w),
    .en_tx_i(ctrl_w.tx_en), .en_rx_i(ctrl_w.rx_en), .en_err_i(ctrl_w.err_en),
    .status_o(status_w), .irq_o(irq)
  );

  sio_baud_gen #(.RATE_W(RATE_W)) u_baud (
    .clk(clk), .rst(rst), .rate_i(rate_w), .restart_i(rate_wr_w), .tick_o(baud_tick)
  );

  assign brk_force   = ctrl_w.brk;
  assign samp_offset = ctrl_w.offset;
  assign rx_thr_sel  = ctrl_w.rx_thr;
  assign tx_thr_sel  = ctrl_w.tx_thr;
  assign idle_sel    = ctrl_w.idle_sel;
endmodule

// File: rtl/sio_hs_regs_chk.sv
module sio_hs_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [4:0] bus_addr,
  input logic [5:0] bus_wdata_lo,
  input logic       rx_empty,
  input logic       rx_pop,
  input logic       tx_push,
  input logic       irq,
  input logic       baud_tick,
  input logic [6:0] status,
  input logic [2:0] en,
  input logic [7:0] rate
);
  logic stat_wr;
  logic src_any;
  assign stat_wr = bus_sel && bus_wr && bus_addr[4:2] == 3'd2;
  assign src_any = (status[0] & en[0]) | ((status[1] | status[2]) & en[1])
                 | ((status[3] | status[4] | status[5]) & en[2]);

  // R3: never pop an empty FIFO
  a_r3_no_empty_pop: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> !rx_empty);

  // R2: unmapped offsets cause no strobe
  a_r2_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_addr[4:2] > 3'd4) |-> (!rx_pop && !tx_push));

  // R6: sticky framing flag holds unless cleared by a one
  a_r6_ferr_sticky: assert property (@(posedge clk) disable iff (rst)
    (status[3] && !(stat_wr && bus_wdata_lo[3])) |=> status[3]);

  // R6: sticky overrun flag holds unless cleared by a one
  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (status[5] && !(stat_wr && bus_wdata_lo[5])) |=> status[5]);

  // R8: interrupt follows the gated sources one cycle later
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(src_any)));

  // R10: with nonzero rate, ticks are never back to back
  a_r10_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (baud_tick && rate != 8'd0) |=> !baud_tick);
endmodule

bind sio_hs_regs sio_hs_regs_chk chk_i (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata_lo(bus_wdata[5:0]), .rx_empty(rx_empty), .rx_pop(rx_pop), .tx_push(tx_push),
  .irq(irq), .baud_tick(baud_tick), .status(status_w),
  .en({ctrl_w.err_en, ctrl_w.rx_en, ctrl_w.tx_en}), .rate(rate_w)
);

// File: tb/sio_hs_regs_tb_top.sv
`timescale 1ns/1ps
module sio_hs_regs_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        bus_sel = 0, bus_wr = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0]  rx_byte = 0, tx_byte, rx_level = 0, tx_level = 0;
  logic        rx_ferr = 0, rx_brk = 0, rx_empty = 1, rx_pop, tx_push;
  logic        ev_tx_req = 0, ev_ferr = 0, ev_brk = 0, ev_ovr = 0, rx_thresh = 0, rx_idle = 0;
  logic        irq, baud_tick, brk_force;
  logic [6:0]  samp_offset;
  logic [2:0]  rx_thr_sel;
  logic [1:0]  tx_thr_sel, idle_sel;

  int tests = 0, fails = 0, pops = 0, pushes = 0;
  logic [7:0] last_tx = 0;

  sio_hs_regs dut_i (.*);

  always @(posedge clk) begin
    if (rx_pop) pops++;
    if (tx_push) begin pushes++; last_tx = tx_byte; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", irq, 0);
    bus_read(5'h0C, d); chk("R1 ctrl", d, 0);
    bus_read(5'h10, d); chk("R1 rate", d, 32'hFF);
    bus_read(5'h08, d); chk("R1 status", d, 0);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    int p0;
    rx_empty = 0; rx_byte = 8'h5A; p0 = pops;
    bus_read(5'h14, d); chk("R2 unmapped 0x14", d, 0);
    bus_read(5'h1C, d); chk("R2 unmapped 0x1C", d, 0);
    chk("R2 no pop", pops - p0, 0);
    rx_level = 8'h12; tx_level = 8'h34;
    bus_read(5'h04, d); chk("R5 levels", d, 32'h3412);
    rx_empty = 1;
  endtask

  task automatic t_data;
    logic [31:0] d;
    int p0;
    p0 = pops; rx_empty = 0; rx_byte = 8'hA5; rx_ferr = 1;
    bus_read(5'h00, d); chk("R3 data+ferr", d, 32'h2A5); chk("R3 pop", pops - p0, 1);
    rx_ferr = 0; rx_brk = 1; rx_byte = 8'h00;
    bus_read(5'h00, d); chk("R3 break", d, 32'h400);
    rx_brk = 0; rx_empty = 1; p0 = pops;
    bus_read(5'h00, d); chk("R3 empty flag", d[8], 1); chk("R3 no pop when empty", pops - p0, 0);
    p0 = pushes;
    bus_write(5'h00, 32'h1C3); chk("R4 push", pushes - p0, 1); chk("R4 byte", last_tx, 8'hC3);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    @(negedge clk); ev_ferr = 1; ev_brk = 1; ev_ovr = 1; ev_tx_req = 1;
    @(negedge clk); ev_ferr = 0; ev_brk = 0; ev_ovr = 0; ev_tx_req = 0;
    bus_read(5'h08, d); chk("R6 latched", d, 32'h39);
    bus_write(5'h08, 32'h0); bus_read(5'h08, d); chk("R6 zero write", d, 32'h39);
    bus_write(5'h08, 32'h08); bus_read(5'h08, d); chk("R6 clear ferr", d, 32'h31);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 5'h08; bus_wdata = 32'h20; ev_ovr = 1;
    @(negedge clk); bus_sel = 0; bus_wr = 0; ev_ovr = 0;
    bus_read(5'h08, d); chk("R6 set beats clear", d, 32'h31);
    bus_write(5'h08, 32'h3F); bus_read(5'h08, d); chk("R6 clear all", d, 0);
  endtask

  task automatic t_levels;
    logic [31:0] d;
    @(negedge clk); rx_thresh = 1; rx_idle = 1;
    bus_read(5'h08, d); chk("R7 follows levels", d, 32'h06);
    bus_write(5'h08, 32'h06); bus_read(5'h08, d); chk("R7 write no effect", d, 32'h06);
    @(negedge clk); rx_thresh = 0; rx_idle = 0;
    bus_read(5'h08, d); chk("R7 drops", d, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    @(negedge clk); ev_ferr = 1; @(negedge clk); ev_ferr = 0;
    cyc(1); chk("R8 masked", irq, 0);
    bus_write(5'h0C, 32'h80); cyc(1); chk("R8 err group", irq, 1);
    bus_write(5'h08, 32'h08); cyc(1); chk("R8 cleared", irq, 0);
    bus_write(5'h0C, 32'h40);
    @(negedge clk); rx_idle = 1; cyc(1); chk("R8 rx group", irq, 1);
    @(negedge clk); rx_idle = 0; cyc(1); chk("R8 rx drop", irq, 0);
    @(negedge clk); ev_tx_req = 1; @(negedge clk); ev_tx_req = 0;
    cyc(1); chk("R8 tx masked", irq, 0);
    bus_read(5'h08, d); chk("R8 bit6 low", d, 32'h01);
    bus_write(5'h0C, 32'h20); cyc(1); chk("R8 tx group", irq, 1);
    bus_read(5'h08, d); chk("R8 bit6 high", d, 32'h41);
    bus_write(5'h08, 32'h01); bus_write(5'h0C, 32'h0); cyc(1); chk("R8 idle", irq, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    bus_write(5'h0C, 32'hFFFFFFFF); bus_read(5'h0C, d); chk("R9 readback", d, 32'h3FFFF);
    chk("R9 brk_force", brk_force, 1); chk("R9 offset max", samp_offset, 7'h7F);
    bus_write(5'h0C, (32'd20 << 9) | 32'h9);
    chk("R9 offset 20", samp_offset, 20); chk("R9 brk off", brk_force, 0);
    chk("R9 rx thr", rx_thr_sel, 3'd2); chk("R9 tx thr", tx_thr_sel, 2'd1);
    bus_write(5'h0C, 32'h0);
  endtask

  task automatic tick_period(input logic [7:0] r, input int exp);
    int n = 0;
    logic [31:0] d;
    bus_write(5'h10, {24'hFFFFFF, r}); bus_read(5'h10, d); chk("R10 rate readback", d, {24'h0, r});
    for (int i = 0; i < 600 && !baud_tick; i++) @(negedge clk);
    do begin @(negedge clk); n++; end while (!baud_tick && n < 600);
    chk("R10 tick period", n, exp);
  endtask

  initial begin
    #2_000_000;
    fails++; $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3); rst = 0;
    t_reset();
    t_decode();
    t_data();
    t_sticky();
    t_levels();
    t_irq();
    t_ctrl();
    tick_period(8'd3, 4);
    tick_period(8'd0, 1);
    tick_period(8'd9, 10);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule